// File: doc/BRIEF.md
# Per-Channel Diagnosis Flag Latch and Status Encoder

This block sits between the fault monitors of a multi-channel low-side switch and the serial interface that reports them. Each channel has three sticky flags: a protection flag, set by an overload or overtemperature indication while the channel is switched on, and an open-load flag and a short-to-ground flag, each set by its comparator while the channel is switched off. A comparator result is ignored when the channel is not in the state that the result belongs to.

The flags are folded into a registered diagnosis word with a two-bit status code per channel. The serial block shifts this word out. After a frame completes successfully, the serial block pulses a clear strobe that empties every flag. Because the flags are sticky, a fault that has come and gone is still reported. A fault that is still present while the clear is applied is caught again on the following clock.

Top module: `diag_status_latch`

## Requirements
- R1: During synchronous reset and in the first cycle after it, every flag is empty and the diagnosis word is all ones, so every channel reads code 11.
- R2: Overload or overtemperature on a channel that is switched on sets its protection flag. The channel's code becomes 10 two clocks after the fault is sampled. It stays 10 after the fault goes away.
- R3: Overload and overtemperature indications on a channel that is switched off are ignored, and its code stays unchanged.
- R4: An open-load indication on a switched-off channel sets its open-load flag, and its code becomes 01. The same indication on a switched-on channel is ignored.
- R5: A short-to-ground indication on a switched-off channel sets its short flag, and its code becomes 00. The same indication on a switched-on channel is ignored.
- R6: When several flags of one channel are set, the code follows this priority: short to ground (00) first, then protection (10), then open load (01). Code 11 means no flag is set.
- R7: A clear strobe sampled at a clock edge empties all flags of all channels at that edge. With no fault present, the word reads all ones one clock later.
- R8: The clear takes precedence over a fault sampled at the same edge. A fault that is still present is latched again at the next edge and reappears in the word one clock after that.
- R9: Channel n's code sits in bits 2n+1 down to 2n of the word, and each channel's code is independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_on | input | NUM_CH | Channel is switched on |
| ovl_ind | input | NUM_CH | Overload indication per channel |
| ovt_ind | input | NUM_CH | Overtemperature indication per channel |
| open_cmp | input | NUM_CH | Open-load comparator result per channel |
| gnd_cmp | input | NUM_CH | Short-to-ground comparator result per channel |
| clr_stb | input | 1 | Clear strobe after a successful frame |
| diag_word | output | 2*NUM_CH | Registered diagnosis word, two bits per channel |

## Verification
The assertions check on every cycle that:
- the word reads all ones after reset;
- a clear empties every flag at the next edge;
- protection flags never drop without a clear and always pick up an on-state fault;
- a latched short always yields code 00 one clock later.

Only the bench's scenarios can show some behaviours: that faults in the wrong switch state are ignored, the full priority order when flags are latched at different times, and the one-cycle gap of code 11 when a persistent fault meets a clear. A reference model drives the random mixes of faults, switch states and clears.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic [1:0] {
    DC_SHORT_GND = 2'b00,
    DC_OPEN_LOAD = 2'b01,
    DC_PROTECT   = 2'b10,
    DC_NORMAL    = 2'b11
  } diag_code_e;

  typedef struct packed {
    logic sg;
    logic prot;
    logic ol;
  } flag_set_t;

endpackage

// File: rtl/diag_flag_cell.sv
module diag_flag_cell
  import diag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_stb,
  input  logic      ch_on,
  input  logic      ovl_ind,
  input  logic      ovt_ind,
  input  logic      open_cmp,
  input  logic      gnd_cmp,
  output flag_set_t flags
);

  logic set_prot, set_ol, set_sg;

  always_comb begin
    set_prot = ch_on & (ovl_ind | ovt_ind);
    set_ol   = ~ch_on & open_cmp;
    set_sg   = ~ch_on & gnd_cmp;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_stb) begin
      flags <= '0;
    end else begin
      flags.prot <= flags.prot | set_prot;
      flags.ol   <= flags.ol   | set_ol;
      flags.sg   <= flags.sg   | set_sg;
    end
  end

endmodule

// File: rtl/diag_code_enc.sv
module diag_code_enc
  import diag_pkg::*;
(
  input  flag_set_t  flags,
  output logic [1:0] code
);

  diag_code_e sel;

  always_comb begin
    if (flags.sg)        sel = DC_SHORT_GND;
    else if (flags.prot) sel = DC_PROTECT;
    else if (flags.ol)   sel = DC_OPEN_LOAD;
    else                 sel = DC_NORMAL;
    code = sel;
  end

endmodule

// File: rtl/diag_word_reg.sv
module diag_word_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= d;
  end

endmodule

// File: rtl/diag_status_latch.sv
module diag_status_latch
  import diag_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   ch_on,
  input  logic [NUM_CH-1:0]   ovl_ind,
  input  logic [NUM_CH-1:0]   ovt_ind,
  input  logic [NUM_CH-1:0]   open_cmp,
  input  logic [NUM_CH-1:0]   gnd_cmp,
  input  logic                clr_stb,
  output logic [2*NUM_CH-1:0] diag_word
);

  localparam int WORD_W = 2 * NUM_CH;

  flag_set_t   flags [NUM_CH];
  logic [WORD_W-1:0] code_vec;
  logic [NUM_CH-1:0] prot_q, ol_q, sg_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    diag_flag_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .clr_stb  (clr_stb),
      .ch_on    (ch_on[ch]),
      .ovl_ind  (ovl_ind[ch]),
      .ovt_ind  (ovt_ind[ch]),
      .open_cmp (open_cmp[ch]),
      .gnd_cmp  (gnd_cmp[ch]),
      .flags    (flags[ch])
    );

    diag_code_enc u_enc (
      .flags (flags[ch]),
      .code  (code_vec[2*ch+1 -: 2])
    );

    assign prot_q[ch] = flags[ch].prot;
    assign ol_q[ch]   = flags[ch].ol;
    assign sg_q[ch]   = flags[ch].sg;
  end

  diag_word_reg #(.WIDTH(WORD_W)) u_word (
    .clk (clk),
    .rst (rst),
    .d   (code_vec),
    .q   (diag_word)
  );

endmodule

// File: rtl/diag_status_latch_chk.sv
module diag_status_latch_chk #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                clr_stb,
  input logic [NUM_CH-1:0]   ch_on,
  input logic [NUM_CH-1:0]   ovl_ind,
  input logic [NUM_CH-1:0]   ovt_ind,
  input logic [NUM_CH-1:0]   prot_q,
  input logic [NUM_CH-1:0]   ol_q,
  input logic [NUM_CH-1:0]   sg_q,
  input logic [2*NUM_CH-1:0] diag_word
);

  p_reset_ones_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (diag_word == '1));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((prot_q | ol_q | sg_q) == '0));

  p_prot_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_stb |=> ((prot_q & $past(prot_q)) == $past(prot_q)));

  p_prot_set_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_stb |=> ((prot_q & $past(ch_on & (ovl_ind | ovt_ind)))
                  == $past(ch_on & (ovl_ind | ovt_ind))));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_sg_code_r6: assert property (@(posedge clk) disable iff (rst)
      sg_q[i] |=> (diag_word[2*i+1 -: 2] == 2'b00));
  end

endmodule

bind diag_status_latch diag_status_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_stb   (clr_stb),
  .ch_on     (ch_on),
  .ovl_ind   (ovl_ind),
  .ovt_ind   (ovt_ind),
  .prot_q    (prot_q),
  .ol_q      (ol_q),
  .sg_q      (sg_q),
  .diag_word (diag_word)
);

// File: tb/diag_status_latch_bench.sv
module diag_status_latch_bench;

  localparam int N      = 8;
  localparam int W      = 2 * N;
  localparam int CLK_PD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ch_on = '0, ovl = '0, ovt = '0, ol = '0, sg = '0;
  logic         clr = 1'b0;
  logic [W-1:0] diag_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit rnd_on = 1'b0;

  always #(CLK_PD/2) clk = ~clk;

  diag_status_latch #(.NUM_CH(N)) u_diag_status_latch (
    .clk(clk), .rst(rst), .ch_on(ch_on), .ovl_ind(ovl), .ovt_ind(ovt),
    .open_cmp(ol), .gnd_cmp(sg), .clr_stb(clr), .diag_word(diag_word)
  );

  // Reference model built from the requirements
  logic [N-1:0] m_prot, m_ol, m_sg;
  logic [W-1:0] m_word;

  function automatic logic [1:0] code_of(bit s, bit p, bit o);
    if (s)      return 2'b00;
    else if (p) return 2'b10;
    else if (o) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [W-1:0] put(logic [W-1:0] w, int ch, logic [1:0] c);
    logic [W-1:0] r = w;
    r[2*ch+1 -: 2] = c;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst || clr) begin
      m_prot <= '0; m_ol <= '0; m_sg <= '0;
    end else begin
      m_prot <= m_prot | (ch_on & (ovl | ovt));
      m_ol   <= m_ol | (~ch_on & ol);
      m_sg   <= m_sg | (~ch_on & sg);
    end
    if (rst) m_word <= '1;
    else for (int i = 0; i < N; i++)
      m_word[2*i+1 -: 2] <= code_of(m_sg[i], m_prot[i], m_ol[i]);
  end

  task automatic chk(string tag, logic [W-1:0] exp);
    n_cmp++;
    if (diag_word !== exp) begin
      n_bad++;
      $display("FAIL %s: diag_word actual %h expected %h", tag, diag_word, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic quiet_clear();
    ch_on = '0; ovl = '0; ovt = '0; ol = '0; sg = '0;
    clr = 1'b1; tick();
    clr = 1'b0; tick();
  endtask

  always @(negedge clk) if (rnd_on) chk("R6 random mix vs model", m_word);

  initial begin
    logic [W-1:0] e;
    void'($urandom(32'd20240611));
    tick(3);
    chk("R1 during reset", '1);
    rst = 1'b0;
    tick();
    chk("R1 after reset", '1);

    // R2: protection while on, sticky
    ch_on[2] = 1'b1; ovl[2] = 1'b1; tick(2);
    e = put('1, 2, 2'b10);
    chk("R2 overload latched", e);
    ovl[2] = 1'b0; tick(2);
    chk("R2 sticky after fault gone", e);

    // R3: protection while off ignored
    ovt[3] = 1'b1; tick(2);
    chk("R3 off-state overtemp ignored", e);
    ovt[3] = 1'b0;
    quiet_clear();
    chk("R7 clear to all ones", '1);

    // R4: open load
    ol[4] = 1'b1; ch_on[5] = 1'b1; ol[5] = 1'b1; tick(2);
    chk("R4 open load off / ignored on", put('1, 4, 2'b01));
    quiet_clear();

    // R5: short to ground
    sg[6] = 1'b1; ch_on[7] = 1'b1; sg[7] = 1'b1; tick(2);
    chk("R5 short off / ignored on", put('1, 6, 2'b00));
    quiet_clear();
    chk("R7 clear after short", '1);

    // R6: priority on channel 0
    ch_on[0] = 1'b1; ovt[0] = 1'b1; tick();
    ch_on[0] = 1'b0; ovt[0] = 1'b0; ol[0] = 1'b1; tick(2);
    chk("R6 protect over open load", put('1, 0, 2'b10));
    sg[0] = 1'b1; tick(2);
    chk("R6 short over protect", put('1, 0, 2'b00));
    quiet_clear();

    // R8: persistent fault across a clear
    sg[1] = 1'b1; tick(2);
    e = put('1, 1, 2'b00);
    chk("R8 short latched", e);
    clr = 1'b1; tick();
    chk("R8 word lags clear", e);
    clr = 1'b0; tick();
    chk("R8 cleared gap", '1);
    tick();
    chk("R8 relatched", e);
    quiet_clear();

    // R9: field position of the top channel
    sg[7] = 1'b1; tick(2);
    chk("R9 top channel field", 16'h3FFF);
    quiet_clear();

    // random phase
    rnd_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      ch_on = N'($urandom);
      ovl   = N'($urandom) & N'($urandom) & N'($urandom);
      ovt   = N'($urandom) & N'($urandom) & N'($urandom);
      ol    = N'($urandom) & N'($urandom) & N'($urandom);
      sg    = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      clr   = ($urandom % 10) == 0;
      @(negedge clk);
    end
    rnd_on = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule